// File: doc/BRIEF.md
# Self-Timed Flash Program and Erase Sequencer

This block runs erase and program cycles on an on-chip flash array. Software writes a 16-bit control word that selects an operation and sets a start flag. It then polls that flag. The sequencer decodes the operation and holds the flag high for a fixed, per-operation number of cycles. When the cycle is over it drops the flag on its own. Three other registers set up the cycle: a page pointer that gates the whole-array erase, a target address, and a 64-entry write latch that holds program data. The array is a behavioural model. Erased words read as all ones, and programming can only turn ones into zeros.

Four operations exist: a whole-array erase, a page erase, a single-word program and a row program. A whole-array erase is refused when the page pointer is at or above the protected threshold. An unknown operation word is also refused. A refused request leaves the array as it was, drops the start flag after a single cycle, and raises a sticky error flag. The top page of the array always survives a whole-array erase. It stands in for the identification and calibration words.

Top module: `nvm_seq_ctrl`

## Requirements
- R1: After reset the control readback is 0x0000, the page pointer reads 0, and every array word reads all ones.
- R2: A control write with bit 15 set and a valid operation makes bit 15 read 1 from the next cycle on. It stays 1 for exactly the cycle count configured for that operation, then clears without software action.
- R3: The configured cycle counts are strictly ordered: whole-array erase > page erase > row program > word program.
- R4: Operation word 0x404F with a page pointer below 0x80 sets every word outside the top page to all ones. The top page is left unchanged.
- R5: Operation word 0x404F with a page pointer of 0x80 or more is refused. Bit 15 reads 1 for one cycle only, bit 13 (error) then reads 1, and no array word changes.
- R6: Operation word 0x4042 sets every word of the page that contains the target address to all ones, and no other word changes.
- R7: Operation word 0x4003 replaces the word at the target address with its old value AND write-latch entry 0, and no other word changes.
- R8: Operation word 0x4001 programs the 64 words starting at the target address rounded down to a multiple of 64. Word i becomes its old value AND latch entry i. Word i is written in busy cycle i, in ascending address order.
- R9: Any other operation word with bit 15 set is refused in the same way as R5.
- R10: The error flag stays set, even across later successful operations, until a control write with bit 13 at 0 arrives. That write clears it, even while a cycle is running.
- R11: While a cycle runs, control writes do not change the stored operation, do not start a new cycle and do not change the busy length.
- R12: A control write while idle stores bits 14 and 12..0 as the operation word, and they read back unchanged. Writing 1 to bit 13 never sets the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write data (bit 15 start, bit 13 error clear when 0) |
| ctl_rdata | output | 16 | Control readback: operation word, busy flag in bit 15, error flag in bit 13 |
| ptr_we | input | 1 | Page pointer write strobe |
| ptr_wdata | input | PTR_W | Page pointer write data |
| ptr_rdata | output | PTR_W | Page pointer readback |
| tgt_we | input | 1 | Target address write strobe |
| tgt_wdata | input | ADDR_W | Target word address |
| lat_we | input | 1 | Write latch strobe |
| lat_idx | input | LIDX_W | Write latch entry index |
| lat_wdata | input | WORD_W | Write latch entry data |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | WORD_W | Array word at rd_addr |

## Verification
The bench targets these corner cases:
- **Whole-array erase:** it is tried with the page pointer on both sides of 0x80. A design with the wrong comparison either wipes protected data or refuses a legal erase. The sweep after each erase also catches an erase that reaches into the top page.
- **Row program:** the bench samples the row word by word while the cycle runs. A design that writes all at once or in the wrong order shows new data too early or old data too late.
- **AND programming:** the same word is programmed twice. A design that overwrites instead of ANDing returns the second latch value.
- **Unknown words:** near-miss operation words are swept. A start written during a running cycle is also tried. A decoder that is too lenient starts a cycle. A sequencer that restarts on the second start lengthens the busy time.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

   localparam int CTL_W     = 16;
   localparam int START_BIT = 15;
   localparam int ERR_BIT   = 13;

   localparam logic [CTL_W-1:0] CODE_CHIP_ERASE = 16'h404F;
   localparam logic [CTL_W-1:0] CODE_PAGE_ERASE = 16'h4042;
   localparam logic [CTL_W-1:0] CODE_WORD_PROG  = 16'h4003;
   localparam logic [CTL_W-1:0] CODE_ROW_PROG   = 16'h4001;

   // bits of the control word that form the stored operation code
   localparam logic [CTL_W-1:0] OP_FIELD_MASK =
      ~((CTL_W'(1) << START_BIT) | (CTL_W'(1) << ERR_BIT));

   typedef enum logic [2:0] {
      K_NONE,
      K_CHIP,
      K_PAGE,
      K_WORD,
      K_ROW
   } op_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RUN,
      ST_REJ
   } seq_state_e;

   function automatic op_kind_e classify(input logic [CTL_W-1:0] op);
      case (op)
         CODE_CHIP_ERASE: classify = K_CHIP;
         CODE_PAGE_ERASE: classify = K_PAGE;
         CODE_WORD_PROG:  classify = K_WORD;
         CODE_ROW_PROG:   classify = K_ROW;
         default:         classify = K_NONE;
      endcase
   endfunction

endpackage

// File: rtl/nvm_seq_decode.sv
module nvm_seq_decode
   import nvm_seq_pkg::*;
#(
   parameter int PTR_W    = 8,
   parameter int PROT_PTR = 128
)(
   input  logic [CTL_W-1:0] op_word,
   input  logic [PTR_W-1:0] page_ptr,
   output op_kind_e         kind,
   output logic             reject
);

   localparam logic [PTR_W-1:0] PROT_LIM = PTR_W'(PROT_PTR);

   initial begin
      AST_PTR_FITS: assert (PROT_PTR > 0 && PROT_PTR < (1 << PTR_W))
         else $error("protection threshold does not fit the pointer width"); // R5
   end

   always_comb begin
      kind   = classify(op_word);
      reject = (kind == K_NONE) || ((kind == K_CHIP) && (page_ptr >= PROT_LIM));
   end

endmodule

// File: rtl/nvm_seq_timer.sv
module nvm_seq_timer
   import nvm_seq_pkg::*;
#(
   parameter int WORD_CYC = 8,
   parameter int ROW_CYC  = 96,
   parameter int PAGE_CYC = 160,
   parameter int CHIP_CYC = 256,
   parameter int CNT_W    = $clog2(CHIP_CYC + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  op_kind_e         kind,
   output logic             busy,
   output logic             last,
   output logic [CNT_W-1:0] step
);

   logic [CNT_W-1:0] dur_m1;
   logic [CNT_W-1:0] end_q;

   initial begin
      AST_DUR_ORDER: assert (CHIP_CYC > PAGE_CYC && PAGE_CYC > ROW_CYC &&
                             ROW_CYC > WORD_CYC && WORD_CYC >= 1)
         else $error("operation durations must be strictly ordered"); // R3
      AST_CNT_WIDE: assert ((1 << CNT_W) > CHIP_CYC)
         else $error("counter too narrow for the longest operation"); // R2
   end

   always_comb begin
      case (kind)
         K_CHIP:  dur_m1 = CNT_W'(CHIP_CYC - 1);
         K_PAGE:  dur_m1 = CNT_W'(PAGE_CYC - 1);
         K_ROW:   dur_m1 = CNT_W'(ROW_CYC - 1);
         default: dur_m1 = CNT_W'(WORD_CYC - 1);
      endcase
   end

   assign last = busy && (step == end_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         step  <= '0;
         end_q <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         step  <= '0;
         end_q <= dur_m1;
      end else if (busy) begin
         if (last) begin
            busy <= 1'b0;
            step <= '0;
         end else begin
            step <= step + CNT_W'(1);
         end
      end
   end

   AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (step <= end_q)); // R2
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy); // R11

endmodule

// File: rtl/nvm_seq_wlatch.sv
module nvm_seq_wlatch #(
   parameter int WORD_W  = 16,
   parameter int ENTRIES = 64,
   parameter int IDX_W   = $clog2(ENTRIES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_data
);

   logic [WORD_W-1:0] buf_q [ENTRIES];

   initial begin
      AST_LATCH_POW2: assert (ENTRIES >= 2 && (1 << IDX_W) == ENTRIES)
         else $error("latch depth must be a power of two"); // R8
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) buf_q[i] <= '1;
      end else if (we) begin
         buf_q[wr_idx] <= wr_data;
      end
   end

   assign rd_data = buf_q[rd_idx];

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(buf_q[0])); // R7

endmodule

// File: rtl/nvm_seq_array.sv
module nvm_seq_array #(
   parameter int WORD_W      = 16,
   parameter int DEPTH       = 512,
   parameter int PAGE_WORDS  = 128,
   parameter bit AND_PROGRAM = 1'b1,
   parameter int ADDR_W      = $clog2(DEPTH),
   parameter int PGIDX_W     = ADDR_W - $clog2(PAGE_WORDS)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               erase_all,
   input  logic               erase_page,
   input  logic [PGIDX_W-1:0] page_idx,
   input  logic               prog_en,
   input  logic [ADDR_W-1:0]  prog_addr,
   input  logic [WORD_W-1:0]  prog_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [WORD_W-1:0]  rd_data
);

   localparam int KEEP_BASE = DEPTH - PAGE_WORDS;

   logic [WORD_W-1:0] mem [DEPTH];
   logic [WORD_W-1:0] prog_val;

   initial begin
      AST_GEOMETRY: assert ((1 << ADDR_W) == DEPTH && DEPTH % PAGE_WORDS == 0 &&
                            DEPTH >= 2 * PAGE_WORDS)
         else $error("array depth must be a power of two holding two or more pages"); // R4
   end

   generate
      if (AND_PROGRAM) begin : g_and_prog
         assign prog_val = mem[prog_addr] & prog_data;
      end else begin : g_direct_prog
         assign prog_val = prog_data;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if ((erase_all && i < KEEP_BASE) ||
                (erase_page && (i / PAGE_WORDS) == int'(page_idx)))
               mem[i] <= '1;
         end
         if (prog_en) mem[prog_addr] <= prog_val;
      end
   end

   assign rd_data = mem[rd_addr];

   AST_TOP_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      erase_all |=> $stable(mem[KEEP_BASE])); // R4
   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({erase_all, erase_page, prog_en})); // R6

endmodule

// File: rtl/nvm_seq_ctrl.sv
module nvm_seq_ctrl
   import nvm_seq_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int DEPTH       = 512,
   parameter int PAGE_WORDS  = 128,
   parameter int ROW_WORDS   = 64,
   parameter int PTR_W       = 8,
   parameter int PROT_PTR    = 128,
   parameter int WORD_CYC    = 8,
   parameter int ROW_CYC     = 96,
   parameter int PAGE_CYC    = 160,
   parameter int CHIP_CYC    = 256,
   parameter bit AND_PROGRAM = 1'b1,
   parameter int ADDR_W      = $clog2(DEPTH),
   parameter int LIDX_W      = $clog2(ROW_WORDS)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [15:0]       ctl_wdata,
   output logic [15:0]       ctl_rdata,
   input  logic              ptr_we,
   input  logic [PTR_W-1:0]  ptr_wdata,
   output logic [PTR_W-1:0]  ptr_rdata,
   input  logic              tgt_we,
   input  logic [ADDR_W-1:0] tgt_wdata,
   input  logic              lat_we,
   input  logic [LIDX_W-1:0] lat_idx,
   input  logic [WORD_W-1:0] lat_wdata,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data
);

   localparam int CNT_W   = $clog2(CHIP_CYC + 1);
   localparam int PG_SH   = $clog2(PAGE_WORDS);
   localparam int PGIDX_W = ADDR_W - PG_SH;

   initial begin
      AST_ROW_FITS: assert (ROW_CYC >= ROW_WORDS && PAGE_WORDS % ROW_WORDS == 0 &&
                            (1 << PG_SH) == PAGE_WORDS)
         else $error("row must fit its cycle and divide a page"); // R8
   end

   seq_state_e        st_q;
   op_kind_e          kind_q;
   op_kind_e          dec_kind;
   logic              dec_rej;
   logic              go;
   logic              tmr_busy;
   logic              tmr_last;
   logic              err_q;
   logic [15:0]       op_q;
   logic [15:0]       op_in;
   logic [PTR_W-1:0]  ptr_q;
   logic [ADDR_W-1:0] tgt_q;
   logic [ADDR_W-1:0] run_addr_q;
   logic [ADDR_W-1:0] prog_addr;
   logic [CNT_W-1:0]  step;
   logic [LIDX_W-1:0] lat_rd_idx;
   logic [WORD_W-1:0] lat_rd_data;
   logic              erase_all;
   logic              erase_page;
   logic              prog_en;
   logic              row_phase;
   logic [PGIDX_W-1:0] page_idx;

   assign op_in = ctl_wdata & OP_FIELD_MASK;
   assign go    = ctl_we && ctl_wdata[START_BIT] && (st_q == ST_IDLE);

   nvm_seq_decode #(
      .PTR_W    (PTR_W),
      .PROT_PTR (PROT_PTR)
   ) u_decode (
      .op_word  (op_in),
      .page_ptr (ptr_q),
      .kind     (dec_kind),
      .reject   (dec_rej)
   );

   nvm_seq_timer #(
      .WORD_CYC (WORD_CYC),
      .ROW_CYC  (ROW_CYC),
      .PAGE_CYC (PAGE_CYC),
      .CHIP_CYC (CHIP_CYC),
      .CNT_W    (CNT_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (go && !dec_rej),
      .kind  (dec_kind),
      .busy  (tmr_busy),
      .last  (tmr_last),
      .step  (step)
   );

   nvm_seq_wlatch #(
      .WORD_W  (WORD_W),
      .ENTRIES (ROW_WORDS),
      .IDX_W   (LIDX_W)
   ) u_wlatch (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (lat_we),
      .wr_idx  (lat_idx),
      .wr_data (lat_wdata),
      .rd_idx  (lat_rd_idx),
      .rd_data (lat_rd_data)
   );

   nvm_seq_array #(
      .WORD_W      (WORD_W),
      .DEPTH       (DEPTH),
      .PAGE_WORDS  (PAGE_WORDS),
      .AND_PROGRAM (AND_PROGRAM),
      .ADDR_W      (ADDR_W),
      .PGIDX_W     (PGIDX_W)
   ) u_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .erase_all  (erase_all),
      .erase_page (erase_page),
      .page_idx   (page_idx),
      .prog_en    (prog_en),
      .prog_addr  (prog_addr),
      .prog_data  (lat_rd_data),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data)
   );

   // array actions: erases and word program land in the final busy cycle,
   // row words stream one per cycle from the start of the busy window
   always_comb begin
      row_phase  = (st_q == ST_RUN) && (kind_q == K_ROW) && (step < CNT_W'(ROW_WORDS));
      erase_all  = tmr_last && (kind_q == K_CHIP);
      erase_page = tmr_last && (kind_q == K_PAGE);
      prog_en    = row_phase || (tmr_last && (kind_q == K_WORD));
      lat_rd_idx = row_phase ? step[LIDX_W-1:0] : '0;
      prog_addr  = row_phase ? {run_addr_q[ADDR_W-1:LIDX_W], step[LIDX_W-1:0]} : run_addr_q;
      page_idx   = run_addr_q[ADDR_W-1:PG_SH];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         kind_q     <= K_NONE;
         op_q       <= '0;
         err_q      <= 1'b0;
         ptr_q      <= '0;
         tgt_q      <= '0;
         run_addr_q <= '0;
      end else begin
         if (ptr_we) ptr_q <= ptr_wdata;
         if (tgt_we) tgt_q <= tgt_wdata;
         if (ctl_we && st_q == ST_IDLE) op_q <= op_in;

         if (st_q == ST_REJ)
            err_q <= 1'b1;
         else if (ctl_we && !ctl_wdata[ERR_BIT])
            err_q <= 1'b0;

         case (st_q)
            ST_IDLE: if (go) begin
               st_q       <= dec_rej ? ST_REJ : ST_RUN;
               kind_q     <= dec_kind;
               run_addr_q <= tgt_q;
            end
            ST_RUN:  if (tmr_last) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      ctl_rdata            = op_q;
      ctl_rdata[START_BIT] = (st_q != ST_IDLE);
      ctl_rdata[ERR_BIT]   = err_q;
   end

   assign ptr_rdata = ptr_q;

   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && !tmr_last) |=> ctl_rdata[START_BIT]); // R2
   AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_last |=> !ctl_rdata[START_BIT]); // R2
   AST_RUN_TRACKS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN) == tmr_busy); // R2
   AST_REJECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_REJ) |=> (st_q == ST_IDLE && err_q)); // R5
   AST_REJECT_NO_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_REJ) |-> !(erase_all || erase_page || prog_en)); // R5
   AST_CHIP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (go && dec_kind == K_CHIP && ptr_q >= PTR_W'(PROT_PTR)) |=> (st_q == ST_REJ)); // R5
   AST_OP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE) |=> $stable(op_q)); // R11
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !(ctl_we && !ctl_wdata[ERR_BIT])) |=> err_q); // R10
   AST_ROW_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (row_phase && step != '0) |-> (prog_addr == $past(prog_addr) + ADDR_W'(1))); // R8

endmodule

// File: tb/nvm_seq_ctrl_tb_top.sv
module nvm_seq_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WORD_W     = 16;
   localparam int DEPTH      = 512;
   localparam int PAGE_WORDS = 128;
   localparam int ROW_WORDS  = 64;
   localparam int PTR_W      = 8;
   localparam int WORD_CYC   = 4;
   localparam int ROW_CYC    = 70;
   localparam int PAGE_CYC   = 90;
   localparam int CHIP_CYC   = 110;
   localparam int ADDR_W     = $clog2(DEPTH);
   localparam int LIDX_W     = $clog2(ROW_WORDS);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ctl_we = 1'b0;
   logic [15:0]       ctl_wdata = '0;
   logic [15:0]       ctl_rdata;
   logic              ptr_we = 1'b0;
   logic [PTR_W-1:0]  ptr_wdata = '0;
   logic [PTR_W-1:0]  ptr_rdata;
   logic              tgt_we = 1'b0;
   logic [ADDR_W-1:0] tgt_wdata = '0;
   logic              lat_we = 1'b0;
   logic [LIDX_W-1:0] lat_idx = '0;
   logic [WORD_W-1:0] lat_wdata = '0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [WORD_W-1:0] rd_data;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [WORD_W-1:0] m_mem [DEPTH];
   logic [WORD_W-1:0] m_lat [ROW_WORDS];

   always #(CLK_PERIOD / 2) clk = ~clk;

   nvm_seq_ctrl #(
      .WORD_W     (WORD_W),
      .DEPTH      (DEPTH),
      .PAGE_WORDS (PAGE_WORDS),
      .ROW_WORDS  (ROW_WORDS),
      .PTR_W      (PTR_W),
      .WORD_CYC   (WORD_CYC),
      .ROW_CYC    (ROW_CYC),
      .PAGE_CYC   (PAGE_CYC),
      .CHIP_CYC   (CHIP_CYC)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (ctl_we),
      .ctl_wdata (ctl_wdata),
      .ctl_rdata (ctl_rdata),
      .ptr_we    (ptr_we),
      .ptr_wdata (ptr_wdata),
      .ptr_rdata (ptr_rdata),
      .tgt_we    (tgt_we),
      .tgt_wdata (tgt_wdata),
      .lat_we    (lat_we),
      .lat_idx   (lat_idx),
      .lat_wdata (lat_wdata),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic ctl_put(input logic [15:0] v);
      @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk); ctl_we = 1'b0;
   endtask

   task automatic ptr_put(input logic [PTR_W-1:0] v);
      @(negedge clk); ptr_we = 1'b1; ptr_wdata = v;
      @(negedge clk); ptr_we = 1'b0;
   endtask

   task automatic tgt_put(input int a);
      @(negedge clk); tgt_we = 1'b1; tgt_wdata = ADDR_W'(a);
      @(negedge clk); tgt_we = 1'b0;
   endtask

   task automatic lat_put(input int k, input logic [WORD_W-1:0] v);
      @(negedge clk); lat_we = 1'b1; lat_idx = LIDX_W'(k); lat_wdata = v;
      @(negedge clk); lat_we = 1'b0;
      m_lat[k] = v;
   endtask

   // counts negedge samples with the start flag high; optionally drives a
   // control write during sample number poke_at
   task automatic count_busy(input int poke_at, input logic [15:0] poke_val, output int n);
      n = 0;
      while (ctl_rdata[15] && n < 5000) begin
         if (n == poke_at) begin ctl_we = 1'b1; ctl_wdata = poke_val; end
         else ctl_we = 1'b0;
         n++;
         @(negedge clk);
      end
      ctl_we = 1'b0;
   endtask

   task automatic sweep(input string req);
      for (int a = 0; a < DEPTH; a++) begin
         rd_addr = ADDR_W'(a);
         #1;
         chk(req, 32'(rd_data), 32'(m_mem[a]));
      end
   endtask

   task automatic model_word(input int a);
      m_mem[a] = m_mem[a] & m_lat[0];
   endtask

   task automatic model_row(input int base);
      for (int i = 0; i < ROW_WORDS; i++) m_mem[base + i] = m_mem[base + i] & m_lat[i];
   endtask

   task automatic model_page(input int p);
      for (int i = 0; i < PAGE_WORDS; i++) m_mem[p * PAGE_WORDS + i] = '1;
   endtask

   task automatic model_chip();
      for (int a = 0; a < DEPTH - PAGE_WORDS; a++) m_mem[a] = '1;
   endtask

   // called right after the start write; consumes ROW_WORDS busy samples
   task automatic row_order(input int base);
      for (int j = 0; j < ROW_WORDS; j++) begin
         if (j % 2 == 0) begin
            rd_addr = ADDR_W'(base + j);
            #1;
            chk("R8 not yet written", 32'(rd_data), 32'(m_mem[base + j]));
         end else begin
            rd_addr = ADDR_W'(base + j - 1);
            #1;
            chk("R8 already written", 32'(rd_data), 32'(m_mem[base + j - 1] & m_lat[j - 1]));
         end
         chk("R8 busy during row", 32'(ctl_rdata[15]), 32'd1);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int n;
      int t_word, t_row, t_page, t_chip;
      logic [15:0] code;

      for (int a = 0; a < DEPTH; a++) m_mem[a] = '1;
      for (int k = 0; k < ROW_WORDS; k++) m_lat[k] = '1;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 control readback", 32'(ctl_rdata), 32'h0);
      chk("R1 page pointer", 32'(ptr_rdata), 32'h0);
      sweep("R1 erased array");

      for (int k = 0; k < ROW_WORDS; k++)
         lat_put(k, 16'h1234 ^ 16'(k * 16'h0101));

      // R7 word program, R2 busy length
      tgt_put(5);
      ctl_put(16'hC003);
      count_busy(-1, 16'h0, n);
      t_word = n;
      chk("R2 word busy length", 32'(n), 32'(WORD_CYC));
      model_word(5);
      sweep("R7 word program");

      // R7 AND semantics on a second program of the same word
      lat_put(0, 16'h0F0F);
      ctl_put(16'hC003);
      count_busy(-1, 16'h0, n);
      model_word(5);
      rd_addr = ADDR_W'(5);
      #1;
      chk("R7 AND programming", 32'(rd_data), 32'h0204);
      sweep("R7 word reprogram");

      // R8 row program, streamed in ascending order
      tgt_put(9'h0C5);
      ctl_put(16'hC001);
      row_order(9'h0C0);
      count_busy(-1, 16'h0, n);
      t_row = n + ROW_WORDS;
      chk("R8 row busy length", 32'(t_row), 32'(ROW_CYC));
      model_row(9'h0C0);
      sweep("R8 row program");

      // R6 page erase on page 1
      tgt_put(9'h0D0);
      ctl_put(16'hC042);
      count_busy(-1, 16'h0, n);
      t_page = n;
      chk("R6 page busy length", 32'(n), 32'(PAGE_CYC));
      model_page(1);
      sweep("R6 page erase");

      // data in the top page and elsewhere before the whole-array erase
      tgt_put(9'h1F0);
      ctl_put(16'hC003);
      count_busy(-1, 16'h0, n);
      model_word(9'h1F0);
      tgt_put(9'h100);
      ctl_put(16'hC003);
      count_busy(-1, 16'h0, n);
      model_word(9'h100);

      // R4 whole-array erase allowed just below the threshold
      ptr_put(8'h7F);
      chk("R4 pointer readback", 32'(ptr_rdata), 32'h7F);
      ctl_put(16'hC04F);
      count_busy(-1, 16'h0, n);
      t_chip = n;
      chk("R4 chip busy length", 32'(n), 32'(CHIP_CYC));
      chk("R4 no error", 32'(ctl_rdata[13]), 32'd0);
      model_chip();
      sweep("R4 chip erase keeps top page");

      // R3 duration ordering measured at the ports
      chk("R3 busy ordering", 32'((t_chip > t_page) && (t_page > t_row) && (t_row > t_word)), 32'd1);

      // reprogram a low word so a wrongful erase would be visible
      tgt_put(9'h010);
      ctl_put(16'hC003);
      count_busy(-1, 16'h0, n);
      model_word(9'h010);

      // R5 refused whole-array erase at and above the threshold
      ptr_put(8'h80);
      ctl_put(16'hC04F);
      count_busy(-1, 16'h0, n);
      chk("R5 refused busy one cycle at 0x80", 32'(n), 32'd1);
      chk("R5 error set", 32'(ctl_rdata[13]), 32'd1);
      sweep("R5 array untouched at 0x80");
      ptr_put(8'hFF);
      ctl_put(16'hE04F);
      count_busy(-1, 16'h0, n);
      chk("R5 refused busy one cycle at 0xFF", 32'(n), 32'd1);
      sweep("R5 array untouched at 0xFF");

      // R10 error survives a successful op started with bit 13 held at 1
      tgt_put(9'h100);
      ctl_put(16'hE003);
      count_busy(-1, 16'h0, n);
      model_word(9'h100);
      chk("R10 error still set", 32'(ctl_rdata[13]), 32'd1);
      sweep("R10 op ran with error set");

      // R10 clear during busy, R11 busy length and op unchanged
      ctl_put(16'hE003);
      count_busy(1, 16'h0000, n);
      model_word(9'h100);
      chk("R11 busy length unchanged", 32'(n), 32'(WORD_CYC));
      chk("R10 error cleared while busy", 32'(ctl_rdata[13]), 32'd0);
      chk("R11 op word kept", 32'(ctl_rdata), 32'h4003);

      // R9 near-miss operation words are refused
      ptr_put(8'h00);
      for (int low = 0; low < 128; low++) begin
         code = 16'h4000 | 16'(low);
         if (code == 16'h404F || code == 16'h4042 || code == 16'h4003 || code == 16'h4001)
            continue;
         ctl_put(code | 16'h8000);
         count_busy(-1, 16'h0, n);
         chk("R9 refused busy one cycle", 32'(n), 32'd1);
         chk("R9 error set", 32'(ctl_rdata[13]), 32'd1);
         ctl_put(code);
         chk("R12 readback and error clear", 32'(ctl_rdata), 32'(code));
      end
      foreach (m_lat[k]) begin
         if (k >= 4) break;
         code = (k == 0) ? 16'h0003 : (k == 1) ? 16'h0042 : (k == 2) ? 16'h504F : 16'h4C01;
         ctl_put(code | 16'h8000);
         count_busy(-1, 16'h0, n);
         chk("R9 refused other word", 32'(n), 32'd1);
         ctl_put(16'h0000);
      end
      sweep("R9 array untouched");

      // R11 a second start during a row program is ignored
      tgt_put(9'h000);
      ctl_put(16'hC001);
      count_busy(5, 16'hC042, n);
      chk("R11 row busy not restarted", 32'(n), 32'(ROW_CYC));
      chk("R11 op word after poke", 32'(ctl_rdata), 32'h4001);
      model_row(0);
      sweep("R11 no page erase happened");

      // R12 idle writes store the op field, bit 13 cannot set the error
      ctl_put(16'h7FFF);
      chk("R12 readback masks error bit", 32'(ctl_rdata), 32'h5FFF);
      ctl_put(16'h4042);
      chk("R12 readback plain", 32'(ctl_rdata), 32'h4042);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule